// File: doc/BRIEF.md
# Windowed Bandwidth Zone Monitor

This block watches the traffic on one bus port and judges how busy that port is over fixed sampling windows. A strobe reports each transfer together with its byte count. The block adds the bytes of one window into a saturating accumulator. The window is timed by ticks of a 19.2 MHz reference that arrive on a strobe input. At the end of each window the total is scaled to count units and compared with three programmable thresholds, which places it in one of four zones.

Each zone carries an action byte. When a window lands in a zone, that byte tells the block which hit counters to increment and which to clear. A zone raises its status bit once its own hit counter reaches a programmed repeat count. Status bits are masked by per-zone enables and then pass through a global enable and pending stage to a level interrupt. For every zone the block also keeps the largest window total seen in that zone. Software reads those maxima to choose its next thresholds.

Top module: `bwz_monitor`

## Requirements
- R1: While monitoring is enabled (bit 0 of word 0), a window ends on every WIN-th reference tick, where WIN is word 2 (a width of 24 bits; 0 acts as 1). The tick count restarts at each window end and on a counter-clear command.
- R2: A window's total in count units is floor(bytes / 2^UNIT_LOG2). The byte accumulator saturates at its all-ones value, so the unit total tops out at 4095 and never wraps.
- R3: The zone is 3 if total > high (word 5), 2 if total > medium (word 4), 1 if total > low (word 3), and 0 otherwise. A total equal to a threshold falls into the lower zone.
- R4: The action word (word 6) holds zone z's action byte at bits 8z+7..8z. When zone h is hit, bit 2z+1 of h's byte increments zone z's hit counter and bit 2z clears it. When both bits are set, the counter restarts at 1. Counters saturate at 255.
- R5: Zone z's status bit (word 8, bit z) sets in the window-end cycle in which an increment brings its counter to equal its repeat byte (word 7, bits 8z+7..8z). A repeat value of 0xFF never sets status.
- R6: Word 16+z holds the largest unit total that landed in zone z since the last clear-all. It is readable at any time.
- R7: Writing word 10 clears each status bit whose data bit is 1. A new set in the same cycle wins. Word 10 reads as 0.
- R8: Status bits set whatever the per-zone enables (word 9) are. Only bits that are set and enabled feed the interrupt path.
- R9: The global pending flag sets one cycle after the global enable (word 11, bit 0) is on and any enabled status bit is set. The irq output is pending AND global enable. Writing word 12 clears pending for one cycle, and it re-asserts if an enabled status bit is still set.
- R10: Writing word 1 with bit 0 set clears the accumulator and the tick count. Bit 1 additionally clears the hit counters, status, maxima and global pending.
- R11: While monitoring is disabled, transfers and ticks are ignored and no window ends.
- R12: A transfer in the window-end cycle counts toward the new window.
- R13: After reset all registers, status, maxima and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock tick |
| xfer_valid | input | 1 | A transfer completes this cycle |
| xfer_bytes | input | BYTE_W | Bytes moved by that transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A table of traffic loads walks the classifier through each zone. It includes totals that sit exactly on the low and high thresholds, which must fall low. A sub-unit remainder shows truncation, and a pair of transfers that would wrap a non-saturating accumulator shows saturation. Repeated hits under different action bytes tell the increment path apart from the clear path and from the repeat count, including the 0xFF setting. A transfer placed exactly on the window-end cycle shows which window it belongs to. Toggling the zone enable, global enable, global clear and local clear shows that status is kept apart from the interrupt.

// File: rtl/bwz_pkg.sv
package bwz_pkg;
  localparam int NZ = 4;
  localparam int AW = 5;
  typedef logic [1:0] zone_t;
  typedef logic [7:0] cnt8_t;
  localparam logic [AW-1:0] A_ENABLE   = 5'd0;
  localparam logic [AW-1:0] A_CMD      = 5'd1;
  localparam logic [AW-1:0] A_WINDOW   = 5'd2;
  localparam logic [AW-1:0] A_THR_LO   = 5'd3;
  localparam logic [AW-1:0] A_THR_MID  = 5'd4;
  localparam logic [AW-1:0] A_THR_HI   = 5'd5;
  localparam logic [AW-1:0] A_ACTIONS  = 5'd6;
  localparam logic [AW-1:0] A_REPEAT   = 5'd7;
  localparam logic [AW-1:0] A_STATUS   = 5'd8;
  localparam logic [AW-1:0] A_ZONE_IE  = 5'd9;
  localparam logic [AW-1:0] A_STAT_CLR = 5'd10;
  localparam logic [AW-1:0] A_GLOB_IE  = 5'd11;
  localparam logic [AW-1:0] A_GLOB_CLR = 5'd12;
endpackage

// File: rtl/bwz_regs.sv
module bwz_regs
  import bwz_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int THR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  input  logic [NZ-1:0]         stat,
  input  logic [NZ*THR_W-1:0]   max_flat,
  output logic [31:0]           rdata,
  output logic                  mon_en,
  output logic [WIN_W-1:0]      win_len,
  output logic [THR_W-1:0]      thr_lo,
  output logic [THR_W-1:0]      thr_mid,
  output logic [THR_W-1:0]      thr_hi,
  output logic [8*NZ-1:0]       actions,
  output logic [8*NZ-1:0]       repeats,
  output logic [NZ-1:0]         zone_ie,
  output logic                  glob_ie,
  output logic                  clr_win,
  output logic                  clr_all,
  output logic [NZ-1:0]         stat_clr,
  output logic                  glob_clr
);
  logic we_en, we_win, we_lo, we_mid, we_hi, we_act, we_rpt, we_ie, we_gie;

  always_comb begin
    we_en  = wr_en && (addr == A_ENABLE);
    we_win = wr_en && (addr == A_WINDOW);
    we_lo  = wr_en && (addr == A_THR_LO);
    we_mid = wr_en && (addr == A_THR_MID);
    we_hi  = wr_en && (addr == A_THR_HI);
    we_act = wr_en && (addr == A_ACTIONS);
    we_rpt = wr_en && (addr == A_REPEAT);
    we_ie  = wr_en && (addr == A_ZONE_IE);
    we_gie = wr_en && (addr == A_GLOB_IE);
    clr_win  = wr_en && (addr == A_CMD) && (wdata[0] || wdata[1]);
    clr_all  = wr_en && (addr == A_CMD) && wdata[1];
    stat_clr = (wr_en && (addr == A_STAT_CLR)) ? wdata[NZ-1:0] : '0;
    glob_clr = wr_en && (addr == A_GLOB_CLR) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en  <= 1'b0;
      win_len <= '0;
      thr_lo  <= '0;
      thr_mid <= '0;
      thr_hi  <= '0;
      actions <= '0;
      repeats <= '0;
      zone_ie <= '0;
      glob_ie <= 1'b0;
    end else begin
      if (we_en)  mon_en  <= wdata[0];
      if (we_win) win_len <= wdata[WIN_W-1:0];
      if (we_lo)  thr_lo  <= wdata[THR_W-1:0];
      if (we_mid) thr_mid <= wdata[THR_W-1:0];
      if (we_hi)  thr_hi  <= wdata[THR_W-1:0];
      if (we_act) actions <= wdata[8*NZ-1:0];
      if (we_rpt) repeats <= wdata[8*NZ-1:0];
      if (we_ie)  zone_ie <= wdata[NZ-1:0];
      if (we_gie) glob_ie <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ENABLE:  rdata[0] = mon_en;
      A_WINDOW:  rdata[WIN_W-1:0] = win_len;
      A_THR_LO:  rdata[THR_W-1:0] = thr_lo;
      A_THR_MID: rdata[THR_W-1:0] = thr_mid;
      A_THR_HI:  rdata[THR_W-1:0] = thr_hi;
      A_ACTIONS: rdata[8*NZ-1:0] = actions;
      A_REPEAT:  rdata[8*NZ-1:0] = repeats;
      A_STATUS:  rdata[NZ-1:0] = stat;
      A_ZONE_IE: rdata[NZ-1:0] = zone_ie;
      A_GLOB_IE: rdata[0] = glob_ie;
      default: begin
        if (addr[4] && (addr[3:2] == 2'b00))
          rdata[THR_W-1:0] = max_flat[int'(addr[1:0])*THR_W +: THR_W];
      end
    endcase
  end
endmodule

// File: rtl/bwz_window.sv
module bwz_window #(
  parameter int WIN_W     = 24,
  parameter int THR_W     = 12,
  parameter int UNIT_LOG2 = 16,
  parameter int BYTE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic              ref_tick,
  input  logic              xfer_valid,
  input  logic [BYTE_W-1:0] xfer_bytes,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              clr,
  output logic              boundary,
  output logic [THR_W-1:0]  total_units
);
  localparam int ACC_W = THR_W + UNIT_LOG2;
  localparam int SUM_W = ((ACC_W > BYTE_W) ? ACC_W : BYTE_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [WIN_W-1:0] tick_q, tick_nxt;
  logic [ACC_W-1:0] acc_q, acc_nxt, base;
  logic [SUM_W-1:0] sum;
  logic             last_tick;

  always_comb begin
    last_tick = ({1'b0, tick_q} + 1'b1) >= {1'b0, win_len};
    boundary  = mon_en && ref_tick && last_tick && !clr;
    total_units = acc_q[ACC_W-1:UNIT_LOG2];

    tick_nxt = tick_q;
    if (clr) tick_nxt = '0;
    else if (mon_en && ref_tick) tick_nxt = last_tick ? '0 : tick_q + 1'b1;

    base = boundary ? '0 : acc_q;
    sum  = SUM_W'(base) + SUM_W'(xfer_bytes);
    acc_nxt = acc_q;
    if (clr) acc_nxt = '0;
    else if (mon_en) begin
      if (xfer_valid)
        acc_nxt = (sum > SUM_W'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
      else
        acc_nxt = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      tick_q <= tick_nxt;
      acc_q  <= acc_nxt;
    end
  end
endmodule

// File: rtl/bwz_zone_engine.sv
module bwz_zone_engine
  import bwz_pkg::*;
#(
  parameter int THR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic [THR_W-1:0]    total,
  input  logic [THR_W-1:0]    thr_lo,
  input  logic [THR_W-1:0]    thr_mid,
  input  logic [THR_W-1:0]    thr_hi,
  input  logic [8*NZ-1:0]     actions,
  input  logic [8*NZ-1:0]     repeats,
  input  logic                clr_all,
  input  logic [NZ-1:0]       stat_clr,
  output logic [NZ-1:0]       stat,
  output logic [NZ*THR_W-1:0] max_flat
);
  zone_t hit_zone;
  cnt8_t act_hit;

  always_comb begin
    if (total > thr_hi)       hit_zone = 2'd3;
    else if (total > thr_mid) hit_zone = 2'd2;
    else if (total > thr_lo)  hit_zone = 2'd1;
    else                      hit_zone = 2'd0;
    act_hit = actions[int'(hit_zone)*8 +: 8];
  end

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    cnt8_t            cnt_q, cnt_nxt, cnt_base, rpt;
    logic [8:0]       cnt_sum;
    logic             inc, clr, set, st_q, st_nxt;
    logic [THR_W-1:0] max_q, max_nxt;

    always_comb begin
      rpt      = repeats[8*z +: 8];
      inc      = boundary && act_hit[2*z+1];
      clr      = boundary && act_hit[2*z];
      cnt_base = clr ? 8'd0 : cnt_q;
      cnt_sum  = {1'b0, cnt_base} + {8'd0, inc};
      cnt_nxt  = cnt_sum[8] ? 8'hFF : cnt_sum[7:0];
      set      = inc && (cnt_nxt == rpt) && (rpt != 8'hFF);
      st_nxt   = (st_q && !stat_clr[z]) || set;
      max_nxt  = max_q;
      if (boundary && (hit_zone == zone_t'(z)) && (total > max_q)) max_nxt = total;
      if (clr_all) begin
        cnt_nxt = '0;
        st_nxt  = 1'b0;
        max_nxt = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        st_q  <= 1'b0;
        max_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
        st_q  <= st_nxt;
        max_q <= max_nxt;
      end
    end

    assign stat[z] = st_q;
    assign max_flat[z*THR_W +: THR_W] = max_q;
  end
endmodule

// File: rtl/bwz_monitor.sv
module bwz_monitor
  import bwz_pkg::*;
#(
  parameter int WIN_W     = 24,
  parameter int THR_W     = 12,
  parameter int UNIT_LOG2 = 16,
  parameter int BYTE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              xfer_valid,
  input  logic [BYTE_W-1:0] xfer_bytes,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                mon_en, glob_ie, clr_win, clr_all, glob_clr, boundary;
  logic [WIN_W-1:0]    win_len;
  logic [THR_W-1:0]    thr_lo, thr_mid, thr_hi, total_units;
  logic [8*NZ-1:0]     actions, repeats;
  logic [NZ-1:0]       zone_ie, stat_clr, stat;
  logic [NZ*THR_W-1:0] max_flat;
  logic                gpend_q, gpend_nxt;

  bwz_regs #(.WIN_W(WIN_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stat(stat), .max_flat(max_flat), .rdata(reg_rdata), .mon_en(mon_en),
    .win_len(win_len), .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
    .actions(actions), .repeats(repeats), .zone_ie(zone_ie), .glob_ie(glob_ie),
    .clr_win(clr_win), .clr_all(clr_all), .stat_clr(stat_clr), .glob_clr(glob_clr)
  );

  bwz_window #(.WIN_W(WIN_W), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2), .BYTE_W(BYTE_W)) u_window (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ref_tick(ref_tick),
    .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .win_len(win_len),
    .clr(clr_win), .boundary(boundary), .total_units(total_units)
  );

  bwz_zone_engine #(.THR_W(THR_W)) u_zones (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .total(total_units),
    .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi), .actions(actions),
    .repeats(repeats), .clr_all(clr_all), .stat_clr(stat_clr),
    .stat(stat), .max_flat(max_flat)
  );

  always_comb begin
    gpend_nxt = gpend_q || (glob_ie && |(stat & zone_ie));
    if (glob_clr || clr_all) gpend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpend_q <= 1'b0;
    else        gpend_q <= gpend_nxt;
  end

  assign irq = gpend_q && glob_ie;
endmodule

// File: rtl/bwz_monitor_checker.sv
module bwz_monitor_checker #(
  parameter int THR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boundary,
  input logic [3:0]         stat,
  input logic [3:0]         zone_ie,
  input logic               glob_ie,
  input logic               gpend_q,
  input logic               glob_clr,
  input logic               clr_all,
  input logic [4*THR_W-1:0] max_flat
);
  assert_pend_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpend_q) |-> $past(glob_ie && |(stat & zone_ie)));

  assert_gclr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(glob_clr) |-> !gpend_q);

  for (genvar z = 0; z < 4; z++) begin : g_chk
    assert_status_at_window_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[z]) |-> $past(boundary));

    assert_max_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_all) |-> (max_flat[z*THR_W +: THR_W] >= $past(max_flat[z*THR_W +: THR_W])));
  end
endmodule

bind bwz_monitor bwz_monitor_checker #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .stat(stat), .zone_ie(zone_ie),
  .glob_ie(glob_ie), .gpend_q(gpend_q), .glob_clr(glob_clr), .clr_all(clr_all),
  .max_flat(max_flat)
);

// File: tb/bwz_monitor_bench.sv
module bwz_monitor_bench;
  localparam int W = 64;
  logic        clk, rst_n, ref_tick, xfer_valid, reg_wr, irq;
  logic [15:0] xfer_bytes;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, v;
  int checks, errors, cyc;

  // nx[47:40] bytes[39:24] zone[23:16] units[15:0]
  localparam logic [47:0] VEC [0:8] = '{
    {8'd0, 16'd0,     8'd0, 16'd0},
    {8'd1, 16'd160,   8'd0, 16'd10},
    {8'd1, 16'd176,   8'd1, 16'd11},
    {8'd2, 16'd160,   8'd1, 16'd20},
    {8'd1, 16'd321,   8'd1, 16'd20},
    {8'd1, 16'd400,   8'd2, 16'd25},
    {8'd1, 16'd480,   8'd2, 16'd30},
    {8'd1, 16'd496,   8'd3, 16'd31},
    {8'd2, 16'd40000, 8'd3, 16'd4095}
  };

  bwz_monitor #(.UNIT_LOG2(4)) u_bwz_monitor (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .xfer_valid(xfer_valid),
    .xfer_bytes(xfer_bytes), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // command write, nx transfers, then wait to 70 cycles after the command edge
  task automatic run(logic [31:0] cmd, int nx, logic [15:0] b);
    wr(5'd1, cmd);
    for (int i = 0; i < nx; i++) begin
      xfer_valid = 1'b1; xfer_bytes = b;
      @(negedge clk);
    end
    xfer_valid = 1'b0;
    repeat (70 - nx) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; ref_tick = 1'b1; xfer_valid = 1'b0; xfer_bytes = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(5'd8, v);  check("R13 status", v, 0);
    rd(5'd2, v);  check("R13 window", v, 0);
    rd(5'd16, v); check("R13 max0", v, 0);
    check("R13 irq", {31'd0, irq}, 0);

    wr(5'd2, W);
    wr(5'd3, 10); wr(5'd4, 20); wr(5'd5, 30);
    wr(5'd6, 32'h95250902);
    wr(5'd7, 32'h01010101);
    wr(5'd9, 32'hF); wr(5'd11, 1); wr(5'd0, 1);

    // R1 R2 R3 R6 R8: table of loads
    foreach (VEC[k]) begin
      run(3, int'(VEC[k][47:40]), VEC[k][39:24]);
      rd(5'd8, v);
      check("R3 zone status", v, 32'd1 << VEC[k][17:16]);
      rd(5'd16 + 5'(VEC[k][17:16]), v);
      check("R2 R6 max units", v, {16'd0, VEC[k][15:0]});
      check("R8 irq", {31'd0, irq}, 1);
    end

    // R12 transfer on the window-end cycle joins the new window (also R1 length)
    wr(5'd1, 3);
    repeat (W - 1) @(negedge clk);
    xfer_valid = 1'b1; xfer_bytes = 16'd496;
    @(negedge clk);
    xfer_valid = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'd8, v); check("R12 first window empty", v, 4'b0001);
    repeat (64) @(negedge clk);
    rd(5'd8, v); check("R12 second window zone3", v, 4'b1001);
    rd(5'd19, v); check("R12 max3", v, 31);

    // R7 write-one-clear, write-only
    wr(5'd10, 1);
    rd(5'd8, v);  check("R7 status after clear", v, 4'b1000);
    rd(5'd10, v); check("R7 clear reads zero", v, 0);

    // R9 global clear re-asserts while local status remains
    check("R9 irq before", {31'd0, irq}, 1);
    wr(5'd12, 1);
    check("R9 irq dropped", {31'd0, irq}, 0);
    @(negedge clk);
    check("R9 irq re-asserted", {31'd0, irq}, 1);
    wr(5'd10, 32'hF);
    wr(5'd12, 1);
    @(negedge clk);
    check("R9 irq stays low", {31'd0, irq}, 0);

    // R5 repeat count of 3
    wr(5'd7, 32'h03010101);
    run(3, 1, 16'd496);
    run(1, 1, 16'd496);
    rd(5'd8, v); check("R5 two hits no status", {28'd0, v[3:0]} & 32'h8, 0);
    run(1, 1, 16'd496);
    rd(5'd8, v); check("R5 third hit sets", {28'd0, v[3:0]} & 32'h8, 8);

    // R5 repeat 0xFF stays quiet
    wr(5'd7, 32'hFF010101);
    run(3, 1, 16'd496);
    run(1, 1, 16'd496);
    rd(5'd8, v); check("R5 0xFF quiet", {28'd0, v[3:0]} & 32'h8, 0);

    // R4 zone1 action clears zone3 counter (bit 6 of zone1 byte)
    wr(5'd7, 32'h02010101);
    wr(5'd6, 32'h95254902);
    run(3, 1, 16'd496);
    run(1, 1, 16'd176);
    run(1, 1, 16'd496);
    rd(5'd8, v); check("R4 cleared counter restarts", {28'd0, v[3:0]} & 32'h8, 0);
    run(1, 1, 16'd496);
    rd(5'd8, v); check("R4 second consecutive hit sets", {28'd0, v[3:0]} & 32'h8, 8);
    wr(5'd6, 32'h95250902);
    wr(5'd7, 32'h01010101);

    // R8 status sets with zone enable off but does not interrupt
    wr(5'd9, 32'hD);
    run(3, 1, 16'd176);
    rd(5'd8, v); check("R8 masked status set", v, 2);
    check("R8 masked irq low", {31'd0, irq}, 0);
    wr(5'd9, 32'hF);
    @(negedge clk);
    check("R8 unmasked irq", {31'd0, irq}, 1);

    // R9 global enable gates output
    wr(5'd11, 0);
    check("R9 global off", {31'd0, irq}, 0);
    wr(5'd11, 1);

    // R10 R11 disabled monitor ignores traffic
    wr(5'd0, 0);
    run(3, 1, 16'd496);
    rd(5'd8, v);  check("R11 no status", v, 0);
    rd(5'd19, v); check("R10 R11 max3 cleared and held", v, 0);
    check("R10 clear-all drops pending", {31'd0, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule